// File: doc/BRIEF.md
# Fast Page DRAM Controller

This block sits between a synchronous host and an asynchronous 16-bit DRAM that has one multiplexed address bus, one row strobe and two column strobes, one for each byte. A host request carries a word address, a read/write flag, two byte enables and write data. The block splits the address into a row half and a column half. It opens the row, strobes the column, and then leaves the row open. A later request to the same row costs only a column strobe and a column precharge.

A request to a different row, or a pending refresh, closes the open row. The block then waits out the row precharge. Refresh uses the column-before-row scheme with W held high. Writes are always early writes, so the DRAM output buffers never turn on during a write. Read data is sampled a fixed number of clocks after the column strobe falls and is returned with a one-cycle valid pulse. All timing is given in clock cycles through parameters.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and on release, the row strobe, both column strobes, W and OE are high, the data bus is not driven and rd_valid is low.
- R2: The row address is req_addr[21:12] and the column address is req_addr[11:0]. Each is presented on dram_a at least one cycle before its strobe falls and is unchanged in the cycle the strobe falls. Data written at an address reads back from that address.
- R3: A request whose row equals the open row is served by column strobes only, with no new falling edge of the row strobe.
- R4: A request to a row other than the open row raises the row strobe, then activates the new row, then serves the request.
- R5: req_be[0] selects the lower byte (bits 7:0) and the lower column strobe. req_be[1] selects the upper byte (bits 15:8) and the upper column strobe. A byte write leaves the other byte of the word unchanged.
- R6: For a write, W is low at least one cycle before a column strobe falls, OE stays high, and the controller drives the data bus while the column strobe is low.
- R7: Read data is sampled T_CAS clock edges after the column strobe falls, and rd_valid is high for exactly one cycle. Byte lanes that are not enabled read as zero.
- R8: A pulse on ref_req produces a refresh. Both column strobes fall at least T_CSR cycles before the row strobe falls, W is high when the row strobe falls, and both column strobes stay low for at least T_CHR cycles after that.
- R9: While a refresh is pending, or ref_req is high, req_ready is low. A host request that is waiting when the refresh is requested is accepted only after the refresh has run.
- R10: Every falling edge of the row strobe is preceded by at least T_RP cycles with the row strobe high.
- R11: A refresh closes the open row, so the next access starts with a new row activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 22 | Word address, row in the upper bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, lanes not enabled are zero |
| ref_req | input | 1 | Refresh request pulse |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the data pads |
| dram_dq_i | input | 16 | Data from the DRAM |

## Verification
A page tracker holding a stale row would show up on the next access. Either a surplus row-strobe fall appears, or, worse, a read returns data from the wrong row. The bench catches both by counting row activations and comparing data. A sequencing fault in the refresh or precharge path shows within one row cycle as a strobe order or spacing violation, which the bench's pin monitor flags. A miscounted capture delay moves rd_valid away from T_CAS edges after the column fall on the very first read.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_PRE, ST_IDLE, ST_ROW, ST_CADR, ST_CAS,
    ST_CPRE, ST_OPEN, ST_RCSR, ST_RHLD, ST_RREC
  } fpm_state_e;

  // Timer load value for a phase lasting n cycles
  function automatic int unsigned ld_of(input int unsigned n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic int unsigned tmax2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Zero the byte lanes that are not enabled
  function automatic logic [15:0] lane_mask(input logic [1:0] be, input logic [15:0] d);
    return d & {{8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
  parameter int CNT_W   = 4,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= CNT_W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_page.sv
module fpm_page #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             hit
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_set) begin
      open_q <= 1'b1;
      row_q  <= set_row;
    end else if (open_clr) begin
      open_q <= 1'b0;
    end
  end

  assign hit = open_q && (row_q == cmp_row);

  AST_PAGE_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_set && open_clr)); // R4
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ADDR_W = 22,
  parameter int ROW_W  = 10,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_CP   = 1,
  parameter int T_CSR  = 1,
  parameter int T_CHR  = 2,
  parameter int T_RREC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [1:0]        req_be,
  input  logic [15:0]       req_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  input  logic              ref_req,
  output logic [11:0]       dram_a,
  output logic              dram_ras_n,
  output logic              dram_lcas_n,
  output logic              dram_ucas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [15:0]       dram_dq_o,
  output logic              dram_dq_oe,
  input  logic [15:0]       dram_dq_i
);
  import fpm_pkg::*;

  localparam int COL_W = ADDR_W - ROW_W;
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_MAX = tmax2(tmax2(tmax2(T_RP, T_RCD), tmax2(T_CAS, T_CP)),
                               tmax2(tmax2(T_CSR, T_CHR), T_RREC));
  localparam int CNT_W = $clog2(T_MAX + 1);

  fpm_state_e       state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             page_hit, accept, ref_pend_q, ref_start, open_set, open_clr;
  logic [ROW_W-1:0] req_row, rq_row;
  logic [COL_W-1:0] req_col, rq_col;
  logic             rq_we;
  logic [1:0]       rq_be;
  logic [15:0]      rq_wdata;
  logic [7:0]       ras_hi_cycles;
  logic             in_row_phase, in_ref_cas;

  assign req_row = req_addr[ADDR_W-1 -: ROW_W];
  assign req_col = req_addr[COL_W-1:0];

  fpm_timer #(.CNT_W(CNT_W), .RST_VAL(ld_of(T_RP))) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done));

  fpm_page #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst_n(rst_n), .open_set(open_set), .open_clr(open_clr),
    .set_row(req_row), .cmp_row(req_row), .hit(page_hit));

  assign req_ready = !(ref_pend_q || ref_req) &&
                     ((state_q == ST_IDLE) || (state_q == ST_OPEN && page_hit));
  assign accept    = req_valid && req_ready;
  assign ref_start = (state_q == ST_IDLE) && ref_pend_q;
  assign open_set  = (state_q == ST_IDLE) && accept;
  assign open_clr  = (state_d == ST_PRE) && (state_q != ST_PRE);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_PRE:  if (tmr_done) state_d = ST_IDLE;
      ST_IDLE:
        if (ref_pend_q) begin
          state_d = ST_RCSR; tmr_load = 1'b1; tmr_val = CNT_W'(ld_of(T_CSR));
        end else if (accept) begin
          state_d = ST_ROW;  tmr_load = 1'b1; tmr_val = CNT_W'(ld_of(T_RCD));
        end
      ST_ROW:  if (tmr_done) state_d = ST_CADR;
      ST_CADR: begin
        state_d = ST_CAS; tmr_load = 1'b1; tmr_val = CNT_W'(ld_of(T_CAS));
      end
      ST_CAS:
        if (tmr_done) begin
          state_d = ST_CPRE; tmr_load = 1'b1; tmr_val = CNT_W'(ld_of(T_CP));
        end
      ST_CPRE: if (tmr_done) state_d = ST_OPEN;
      ST_OPEN:
        if (ref_pend_q || (req_valid && !page_hit)) begin
          state_d = ST_PRE; tmr_load = 1'b1; tmr_val = CNT_W'(ld_of(T_RP));
        end else if (accept) begin
          state_d = ST_CADR;
        end
      ST_RCSR:
        if (tmr_done) begin
          state_d = ST_RHLD; tmr_load = 1'b1; tmr_val = CNT_W'(ld_of(T_CHR));
        end
      ST_RHLD:
        if (tmr_done) begin
          state_d = ST_RREC; tmr_load = 1'b1; tmr_val = CNT_W'(ld_of(T_RREC));
        end
      ST_RREC:
        if (tmr_done) begin
          state_d = ST_PRE; tmr_load = 1'b1; tmr_val = CNT_W'(ld_of(T_RP));
        end
      default: state_d = ST_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_PRE;
      ref_pend_q <= 1'b0;
      rq_row     <= '0;
      rq_col     <= '0;
      rq_we      <= 1'b0;
      rq_be      <= 2'b00;
      rq_wdata   <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      ras_hi_cycles <= '0;
    end else begin
      state_q    <= state_d;
      ref_pend_q <= (ref_pend_q && !ref_start) || ref_req;
      if (accept) begin
        rq_row   <= req_row;
        rq_col   <= req_col;
        rq_we    <= req_we;
        rq_be    <= req_be;
        rq_wdata <= req_wdata;
      end
      rd_valid <= (state_q == ST_CAS) && tmr_done && !rq_we;
      if ((state_q == ST_CAS) && tmr_done && !rq_we)
        rd_data <= lane_mask(rq_be, dram_dq_i);
      if (!dram_ras_n) ras_hi_cycles <= '0;
      else if (ras_hi_cycles != 8'hFF) ras_hi_cycles <= ras_hi_cycles + 8'd1;
    end
  end

  // Pin decode
  assign in_row_phase = (state_q == ST_ROW) || (state_q == ST_CADR) || (state_q == ST_CAS);
  assign in_ref_cas   = (state_q == ST_RCSR) || (state_q == ST_RHLD);
  assign dram_ras_n   = (state_q == ST_PRE) || (state_q == ST_IDLE) || (state_q == ST_RCSR);
  assign dram_lcas_n  = !(((state_q == ST_CAS) && rq_be[0]) || in_ref_cas);
  assign dram_ucas_n  = !(((state_q == ST_CAS) && rq_be[1]) || in_ref_cas);
  assign dram_we_n    = !(rq_we && in_row_phase);
  assign dram_oe_n    = !(!rq_we && (state_q == ST_CAS));
  assign dram_dq_oe   = rq_we && ((state_q == ST_CADR) || (state_q == ST_CAS));
  assign dram_dq_o    = rq_wdata;

  always_comb begin
    if (state_q == ST_IDLE)     dram_a = 12'(MA_W'(req_row));
    else if (state_q == ST_ROW) dram_a = 12'(MA_W'(rq_row));
    else                        dram_a = 12'(MA_W'(rq_col));
  end

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_cycles >= 8'(T_RP))); // R10
  AST_ROW_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && dram_lcas_n && dram_ucas_n) |-> $stable(dram_a)); // R2
  AST_COL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_ras_n) |-> $stable(dram_a)); // R2
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_lcas_n) |-> (dram_we_n && $past(!dram_lcas_n && !dram_ucas_n))); // R8
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n) |-> ($past(!dram_we_n) && dram_oe_n)); // R6
  AST_OE_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (dram_we_n && !dram_dq_oe)); // R6
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7
endmodule

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb;
  localparam int T_RP = 3, T_CAS = 2, T_CSR = 1, T_CHR = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] rd_data, dram_dq_o, dram_dq_i;
  logic [11:0] dram_a;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ras_falls = 0, cbr_cnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fpm_dram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o),
    .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i));

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [21:0] mk(input int row, input int col);
    return {10'(row), 12'(col)};
  endfunction

  // Behavioural DRAM model and pin monitor
  logic [15:0] mem [1024];
  logic [11:0] m_row, m_col;
  logic p_ras = 1, p_lcas = 1, p_ucas = 1, p_we = 1, p_rdv = 0, in_cbr = 0;
  int ras_hi_run = 0, cas_lo_run = 0, chr_run = 0, cas_fall_cyc = 0;
  wire [9:0] idx = {m_row[4:0], m_col[4:0]};
  wire rd_en = !dram_ras_n && !dram_oe_n && dram_we_n;
  assign dram_dq_i = {(rd_en && !dram_ucas_n) ? mem[idx][15:8] : 8'hEE,
                      (rd_en && !dram_lcas_n) ? mem[idx][7:0]  : 8'hEE};

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    end else begin
      if (p_ras && !dram_ras_n) begin
        chk(ras_hi_run >= T_RP, "R10 row strobe high cycles before fall", ras_hi_run, T_RP);
        if (!dram_lcas_n && !dram_ucas_n) begin
          cbr_cnt++;
          chk(dram_we_n == 1'b1, "R8 W high at refresh row fall", int'(dram_we_n), 1);
          chk(cas_lo_run >= T_CSR, "R8 column strobes low before row fall", cas_lo_run, T_CSR);
          in_cbr = 1; chr_run = 0;
        end else begin
          ras_falls++;
          m_row = dram_a;
        end
      end
      if (in_cbr) begin
        if (!dram_lcas_n && !dram_ucas_n) chr_run++;
        else begin
          chk(chr_run >= T_CHR, "R8 column hold after refresh row fall", chr_run, T_CHR);
          in_cbr = 0;
        end
      end
      if (!dram_ras_n && ((p_lcas && !dram_lcas_n) || (p_ucas && !dram_ucas_n))) begin
        m_col = dram_a;
        cas_fall_cyc = cyc;
        if (!dram_we_n) begin
          chk(p_we == 1'b0, "R6 W low before column fall", int'(p_we), 0);
          chk(dram_oe_n && dram_dq_oe, "R6 OE high and bus driven", int'({dram_oe_n, dram_dq_oe}), 3);
          if (!dram_lcas_n) mem[{m_row[4:0], dram_a[4:0]}][7:0]  = dram_dq_o[7:0];
          if (!dram_ucas_n) mem[{m_row[4:0], dram_a[4:0]}][15:8] = dram_dq_o[15:8];
        end
      end
      if (rd_valid) begin
        chk(!p_rdv, "R7 rd_valid single cycle", int'(p_rdv), 0);
        chk(cyc - cas_fall_cyc == T_CAS, "R7 capture delay", cyc - cas_fall_cyc, T_CAS);
      end
      ras_hi_run = dram_ras_n ? ras_hi_run + 1 : 0;
      cas_lo_run = (!dram_lcas_n && !dram_ucas_n) ? cas_lo_run + 1 : 0;
      p_ras = dram_ras_n; p_lcas = dram_lcas_n; p_ucas = dram_ucas_n;
      p_we = dram_we_n; p_rdv = rd_valid;
    end
  end

  task automatic host(input logic [21:0] addr, input bit we, input logic [1:0] be,
                      input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    req_addr = addr; req_we = we; req_be = be; req_wdata = wd; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    rd = '0;
    if (!we) begin
      while (!rd_valid) @(negedge clk);
      rd = rd_data;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n} == 5'h1F,
        "R1 strobes high in reset", int'({dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n}), 'h1F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dram_dq_oe && !rd_valid && dram_ras_n, "R1 idle after reset",
        int'({dram_dq_oe, rd_valid, dram_ras_n}), 1);
  endtask

  task automatic t_page_hit;
    logic [15:0] r;
    int f0 = ras_falls;
    host(mk(5, 3), 1, 2'b11, 16'h1234, r);
    host(mk(5, 4), 1, 2'b11, 16'h5678, r);
    host(mk(5, 3), 0, 2'b11, 16'h0, r);
    chk(r == 16'h1234, "R2 read back col 3", r, 'h1234);
    host(mk(5, 4), 0, 2'b11, 16'h0, r);
    chk(r == 16'h5678, "R2 read back col 4", r, 'h5678);
    chk(ras_falls - f0 == 1, "R3 one activation for same-row accesses", ras_falls - f0, 1);
  endtask

  task automatic t_byte_lanes;
    logic [15:0] r;
    host(mk(5, 3), 1, 2'b01, 16'hBBCC, r);
    host(mk(5, 3), 0, 2'b11, 16'h0, r);
    chk(r == 16'h12CC, "R5 lower byte write", r, 'h12CC);
    host(mk(5, 3), 1, 2'b10, 16'h77FF, r);
    host(mk(5, 3), 0, 2'b11, 16'h0, r);
    chk(r == 16'h77CC, "R5 upper byte write", r, 'h77CC);
    host(mk(5, 3), 0, 2'b01, 16'h0, r);
    chk(r == 16'h00CC, "R7 disabled upper lane reads zero", r, 'h00CC);
    host(mk(5, 3), 0, 2'b10, 16'h0, r);
    chk(r == 16'h7700, "R7 disabled lower lane reads zero", r, 'h7700);
  endtask

  task automatic t_page_miss;
    logic [15:0] r;
    int f0 = ras_falls;
    host(mk(9, 3), 1, 2'b11, 16'h9999, r);
    host(mk(5, 3), 0, 2'b11, 16'h0, r);
    chk(r == 16'h77CC, "R2 other row unchanged", r, 'h77CC);
    chk(ras_falls - f0 == 2, "R4 activation per row change", ras_falls - f0, 2);
    host(mk(9, 3), 0, 2'b11, 16'h0, r);
    chk(r == 16'h9999, "R4 data after row change", r, 'h9999);
    chk(ras_falls - f0 == 3, "R4 activation count", ras_falls - f0, 3);
  endtask

  task automatic t_refresh_open;
    logic [15:0] r;
    int c0 = cbr_cnt, f0 = ras_falls;
    @(negedge clk); ref_req = 1'b1;
    @(negedge clk); ref_req = 1'b0;
    repeat (25) @(negedge clk);
    chk(cbr_cnt - c0 == 1, "R8 one refresh per pulse", cbr_cnt - c0, 1);
    host(mk(9, 3), 0, 2'b11, 16'h0, r);
    chk(ras_falls - f0 == 1, "R11 row reopened after refresh", ras_falls - f0, 1);
    chk(r == 16'h9999, "R11 data after refresh", r, 'h9999);
  endtask

  task automatic t_priority;
    int c0 = cbr_cnt;
    @(negedge clk);
    ref_req = 1'b1; req_valid = 1'b1; req_we = 1'b0; req_be = 2'b11; req_addr = mk(9, 3);
    #1;
    chk(!req_ready, "R9 ready low with refresh request", int'(req_ready), 0);
    @(negedge clk); ref_req = 1'b0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    chk(cbr_cnt - c0 == 1, "R9 refresh done before accept", cbr_cnt - c0, 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!rd_valid) @(negedge clk);
    chk(rd_data == 16'h9999, "R9 waiting read served", rd_data, 'h9999);
  endtask

  bit done_flag = 0;

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_page_hit();
    t_byte_lanes();
    t_page_miss();
    t_refresh_open();
    t_priority();
    repeat (5) @(negedge clk);
    done_flag = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "watchdog expired", 0, 1);
      report();
    end
  end
endmodule